// File: doc/BRIEF.md
# BCD Real-Time Clock Core

This block keeps calendar time in packed-BCD fields: seconds, minutes, hours, day of week, date of month, month and a two-digit year, together with a halt flag. A prescaler counts pulses of a base-rate enable, `tick_en`. When it has counted `TICKS_PER_SEC` of them, the stored time advances by one second. Carries run from seconds through minutes and hours into the calendar. Month lengths are honoured, and February has 29 days in every year whose value is a multiple of four, year 00 included.

A bus front end reaches every field through a small register port. It drives a word address, a write strobe and a byte of write data, and it receives combinational read data for the addressed register. The hour register holds either a 24-hour value or a 12-hour value with a PM flag, chosen by a format bit stored in the same byte. A write takes effect at the next clock edge and zeroes the prescaler, so a freshly written seconds value lasts one full second.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read 0x00 (address 0, seconds with halt clear), 0x00 (address 1, minutes), 0x00 (address 2, hour 00 in 24-hour format), 0x01 (address 3, weekday), 0x01 (address 4, date), 0x01 (address 5, month) and 0x00 (address 6, year).
- R2: The register map is as follows. Address 0 holds halt in bit 7 and BCD seconds in bits 6:0. Address 1 holds BCD minutes in bits 6:0. Address 2 holds the hour byte. Address 3 holds the weekday 1–7 in bits 2:0. Address 4 holds the BCD date in bits 5:0. Address 5 holds the BCD month in bits 4:0. Address 6 holds the 8-bit BCD year. Unused bits read 0, and address 7 reads 0x00 and ignores writes.
- R3: Each second advance moves seconds 59 to 00 with a carry into minutes, and minutes 59 to 00 with a carry into the hour.
- R4: With address 2 bit 6 clear (24-hour format, bits 5:0 BCD 00–23), a carry out of hour 23 gives hour 00 and advances the date and the weekday.
- R5: With address 2 bit 6 set (12-hour format, bit 5 = PM, bits 4:0 BCD 01–12), hour 11 steps to 12 and toggles PM, and hour 12 steps to 01. The date advances only on the step from 11 PM to 12 AM.
- R6: The weekday steps from 7 to 1 when the date advances.
- R7: The date wraps to 01 after the last day of the month: day 30 for months 04, 06, 09 and 11, day 31 for the other months other than February. The month then advances, and month 12 wraps to 01 while the year advances, 99 wrapping to 00.
- R8: February ends on day 29 when the BCD year is a multiple of four (00 included), and on day 28 otherwise.
- R9: While the halt bit is 1, no field changes on `tick_en` pulses and the prescaler is held at zero.
- R10: The time advances once per `TICKS_PER_SEC` cycles with `tick_en` high. Any register write zeroes that count.
- R11: A write updates its register at the next clock edge and takes priority over a second advance due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base-rate count enable for the prescaler |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |

## Verification
The bench targets the carry boundaries: the end of the century, the 30-day and 31-day month ends, and February in leap and common years, including year 00. It also drives the 12-hour transitions around 11 and 12 in both halves of the day. A design that got these wrong would skip or repeat a date, carry the date on noon or at 12→01, or leave PM unchanged. The bench checks that halt freezes every field and that a write both restarts the prescale and wins over a coincident advance; a design wrong there would let a written second expire early or be overwritten. Random loads and irregular `tick_en` patterns are compared against an integer calendar model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int A_SEC   = 0;
  localparam int A_MIN   = 1;
  localparam int A_HOUR  = 2;
  localparam int A_WDAY  = 3;
  localparam int A_DATE  = 4;
  localparam int A_MONTH = 5;
  localparam int A_YEAR  = 6;

  typedef struct packed {
    logic       halt;
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;   // [6] 12h format, [5] PM or tens, [4:0] value
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{halt: 1'b0, sec: 7'h00, min: 7'h00,
                                     hour: 7'h00, wday: 3'd1, date: 6'h01,
                                     month: 5'h01, year: 8'h00};

  // Two-digit BCD increment without wrap handling
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Multiple of four for a BCD year: even tens -> units 0/4/8, odd tens -> 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) bcd_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      bcd_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic clear,
  output logic sec_pulse
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign sec_pulse = tick_en && (cnt_q == LAST);
  assign cnt_en    = clear || tick_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || sec_pulse) cnt_d = '0;
    else if (tick_en)       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10
  prescale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R10
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic       carry_min, carry_hour, carry_day;
  logic [5:0] last_date;

  always_comb begin
    case (cur.month)
      5'h02:                      last_date = bcd_leap(cur.year) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase
  end

  always_comb begin
    nxt        = cur;
    carry_min  = 1'b0;
    carry_hour = 1'b0;
    carry_day  = 1'b0;

    if (cur.sec == 7'h59) begin
      nxt.sec   = 7'h00;
      carry_min = 1'b1;
    end else begin
      nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));
    end

    if (carry_min) begin
      if (cur.min == 7'h59) begin
        nxt.min    = 7'h00;
        carry_hour = 1'b1;
      end else begin
        nxt.min = 7'(bcd_inc({1'b0, cur.min}));
      end
    end

    if (carry_hour) begin
      if (cur.hour[6]) begin
        if (cur.hour[4:0] == 5'h11) begin
          nxt.hour[4:0] = 5'h12;
          nxt.hour[5]   = ~cur.hour[5];
          carry_day     = cur.hour[5];
        end else if (cur.hour[4:0] == 5'h12) begin
          nxt.hour[4:0] = 5'h01;
        end else begin
          nxt.hour[4:0] = 5'(bcd_inc({3'b000, cur.hour[4:0]}));
        end
      end else begin
        if (cur.hour[5:0] == 6'h23) begin
          nxt.hour[5:0] = 6'h00;
          carry_day     = 1'b1;
        end else begin
          nxt.hour[5:0] = 6'(bcd_inc({2'b00, cur.hour[5:0]}));
        end
      end
    end

    if (carry_day) begin
      nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
      if (cur.date >= last_date) begin
        nxt.date = 6'h01;
        if (cur.month == 5'h12) begin
          nxt.month = 5'h01;
          nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
        end else begin
          nxt.month = 5'(bcd_inc({3'b000, cur.month}));
        end
      end else begin
        nxt.date = 6'(bcd_inc({2'b00, cur.date}));
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  logic      rst_q_n;
  logic      sec_pulse, adv_en, upd_en, pre_clear;
  rtc_time_t t_q, t_d, t_adv;

  rtc_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q_n));

  assign pre_clear = wr_en || t_q.halt;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_prescaler (
    .clk(clk), .rst_n(rst_q_n), .tick_en(tick_en),
    .clear(pre_clear), .sec_pulse(sec_pulse)
  );

  rtc_advance i_advance (.cur(t_q), .nxt(t_adv));

  assign adv_en = sec_pulse && !t_q.halt && !wr_en;
  assign upd_en = wr_en || adv_en;

  always_comb begin
    t_d = t_q;
    if (wr_en) begin
      if      (addr == ADDR_W'(A_SEC))   {t_d.halt, t_d.sec} = wr_data;
      else if (addr == ADDR_W'(A_MIN))   t_d.min   = wr_data[6:0];
      else if (addr == ADDR_W'(A_HOUR))  t_d.hour  = wr_data[6:0];
      else if (addr == ADDR_W'(A_WDAY))  t_d.wday  = wr_data[2:0];
      else if (addr == ADDR_W'(A_DATE))  t_d.date  = wr_data[5:0];
      else if (addr == ADDR_W'(A_MONTH)) t_d.month = wr_data[4:0];
      else if (addr == ADDR_W'(A_YEAR))  t_d.year  = wr_data;
    end else if (adv_en) begin
      t_d = t_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    t_q <= RTC_RESET;
    else if (upd_en) t_q <= t_d;
  end

  always_comb begin
    rd_data = 8'h00;
    if      (addr == ADDR_W'(A_SEC))   rd_data = {t_q.halt, t_q.sec};
    else if (addr == ADDR_W'(A_MIN))   rd_data = {1'b0, t_q.min};
    else if (addr == ADDR_W'(A_HOUR))  rd_data = {1'b0, t_q.hour};
    else if (addr == ADDR_W'(A_WDAY))  rd_data = {5'b0, t_q.wday};
    else if (addr == ADDR_W'(A_DATE))  rd_data = {2'b0, t_q.date};
    else if (addr == ADDR_W'(A_MONTH)) rd_data = {3'b0, t_q.month};
    else if (addr == ADDR_W'(A_YEAR))  rd_data = t_q.year;
  end

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adv_en && t_q.sec == 7'h59) |=> (t_q.sec == 7'h00));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (t_q.halt && !wr_en) |=> $stable(t_q));

  // R11
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && addr == ADDR_W'(A_SEC)) |=> ({t_q.halt, t_q.sec} == $past(wr_data)));

  // R5
  noon_no_date_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!wr_en && t_q.hour[6] && t_q.hour[4:0] != 5'h11) |=> $stable(t_q.date));
endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  // bench calendar model, plain integers
  int m_s, m_m, m_h, m_pm, m_12, m_wd, m_d, m_mo, m_y, m_halt, m_cnt;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS), .ADDR_W(3)) i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int month_days(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(int a);
    case (a)
      0: return {m_halt[0], 7'(to_bcd(m_s))};
      1: return to_bcd(m_m);
      2: return m_12 ? {2'b01, m_pm[0], 5'(to_bcd(m_h))} : to_bcd(m_h);
      3: return 8'(m_wd);
      4: return to_bcd(m_d);
      5: return to_bcd(m_mo);
      6: return to_bcd(m_y);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_day();
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_d++;
    if (m_d > month_days(m_mo, m_y)) begin
      m_d = 1;
      m_mo++;
      if (m_mo > 12) begin m_mo = 1; m_y = (m_y + 1) % 100; end
    end
  endtask

  task automatic model_second();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0;
    if (m_12) begin
      if (m_h == 11) begin
        m_h = 12; m_pm = 1 - m_pm;
        if (m_pm == 0) model_day();
      end else if (m_h == 12) m_h = 1;
      else m_h++;
    end else begin
      m_h++;
      if (m_h == 24) begin m_h = 0; model_day(); end
    end
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    tick_en = 1'b0; addr = 3'(a);
    #1 v = rd_data;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    tick_en = 1'b0; addr = 3'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_cnt = 0;
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk(req, v, exp_reg(a));
    end
  endtask

  task automatic load(int h12, int pm, int h, int mi, int s, int wd,
                      int d, int mo, int y, int halt);
    m_12 = h12; m_pm = pm; m_h = h; m_m = mi; m_s = s; m_wd = wd;
    m_d = d; m_mo = mo; m_y = y; m_halt = halt;
    for (int a = 0; a < 7; a++) wr(a, exp_reg(a));
    m_cnt = 0;
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = rnd ? 1'($urandom % 2) : 1'b1;
      if (m_halt != 0) m_cnt = 0;
      else if (tick_en) begin
        m_cnt++;
        if (m_cnt == TPS) begin m_cnt = 0; model_second(); end
      end
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1307));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    m_12 = 0; m_pm = 0; m_h = 0; m_m = 0; m_s = 0; m_wd = 1;
    m_d = 1; m_mo = 1; m_y = 0; m_halt = 0; m_cnt = 0;
    check_all("R1");

    // R2 unused bits read zero, address 7 inert
    wr(3, 8'hFF); rd(3, v); chk("R2", v, 8'h07);
    wr(1, 8'hFF); rd(1, v); chk("R2", v, 8'h7F);
    wr(4, 8'hFF); rd(4, v); chk("R2", v, 8'h3F);
    wr(7, 8'hA5); rd(7, v); chk("R2", v, 8'h00);

    // R3 R4 R6 R7 century rollover, weekday 7 -> 1
    load(0, 0, 23, 59, 59, 7, 31, 12, 99, 0);
    run(TPS, 0); check_all("R7");
    rd(3, v); chk("R6", v, 8'h01);
    rd(2, v); chk("R4", v, 8'h00);
    rd(1, v); chk("R3", v, 8'h00);

    // R7 thirty-day month
    load(0, 0, 23, 59, 59, 3, 30, 4, 21, 0);
    run(TPS, 0); check_all("R7");

    // R8 leap years, including 00, and a common year
    load(0, 0, 23, 59, 59, 2, 28, 2, 24, 0);
    run(TPS, 0); rd(4, v); chk("R8", v, 8'h29);
    load(0, 0, 23, 59, 59, 2, 29, 2, 24, 0);
    run(TPS, 0); rd(5, v); chk("R8", v, 8'h03);
    load(0, 0, 23, 59, 59, 2, 28, 2, 0, 0);
    run(TPS, 0); rd(4, v); chk("R8", v, 8'h29);
    load(0, 0, 23, 59, 59, 2, 28, 2, 23, 0);
    run(TPS, 0); check_all("R8");

    // R5 12-hour transitions
    load(1, 1, 11, 59, 59, 5, 10, 6, 30, 0);
    run(TPS, 0); check_all("R5");
    rd(2, v); chk("R5", v, 8'h52);
    load(1, 0, 11, 59, 59, 5, 10, 6, 30, 0);
    run(TPS, 0); check_all("R5");
    rd(4, v); chk("R5", v, 8'h10);
    load(1, 1, 12, 59, 59, 5, 10, 6, 30, 0);
    run(TPS, 0); rd(2, v); chk("R5", v, 8'h61);

    // R9 halt freezes everything
    load(0, 0, 10, 20, 30, 2, 15, 8, 40, 1);
    run(5 * TPS, 0); check_all("R9");
    wr(0, 8'h30); m_halt = 0;
    run(TPS, 0); rd(0, v); chk("R9", v, 8'h31);

    // R10 prescale length and restart on write
    load(0, 0, 1, 2, 3, 1, 1, 1, 1, 0);
    run(TPS - 1, 0); rd(0, v); chk("R10", v, 8'h03);
    run(1, 0); rd(0, v); chk("R10", v, 8'h04);
    run(TPS - 1, 0); wr(1, 8'h02);
    run(TPS - 1, 0); rd(0, v); chk("R10", v, 8'h04);
    run(1, 0); rd(0, v); chk("R10", v, 8'h05);

    // R11 write wins over a due advance
    load(0, 0, 1, 2, 3, 1, 1, 1, 1, 0);
    run(TPS - 1, 0);
    @(negedge clk);
    addr = 3'd0; wr_data = 8'h42; wr_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    m_s = 42; m_cnt = 0;
    rd(0, v); chk("R11", v, 8'h42);
    run(TPS - 1, 0); rd(0, v); chk("R11", v, 8'h42);

    // R3 R10 random loads with irregular tick enables
    for (int it = 0; it < 30; it++) begin
      int mo, yr, h12;
      mo  = 1 + int'($urandom % 12);
      yr  = int'($urandom % 100);
      h12 = int'($urandom % 2);
      load(h12, int'($urandom % 2),
           h12 ? 1 + int'($urandom % 12) : int'($urandom % 24),
           55 + int'($urandom % 5), 50 + int'($urandom % 10),
           1 + int'($urandom % 7),
           month_days(mo, yr) - int'($urandom % 2), mo, yr, 0);
      run(20 + int'($urandom % 60), 1);
      check_all("R3");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule